// File: doc/BRIEF.md
# Partitioned Victim Allocator for a Shared Set-Associative Cache

This block chooses which way of a shared 16-way cache receives a new line on a fill. The cache is shared by up to eight cores and a set of external agents. Each of them is identified by a requester ID. Software programs up to four partition groups. Each group holds a mask of the ways it owns and a mask of the requester IDs that belong to it. Software may rewrite any group while traffic runs, and no reset is needed.

On a fill, the requester ID is resolved to an allowed way subset:
- A requester that belongs to a group may use only the ways of that group.
- A requester that belongs to no group shares the ways that no group owns.

The victim is then chosen by a tree pseudo-LRU walk that stays inside that subset. Lookups are not restricted: a hit in any way, including a way owned by another group, refreshes that way's recency. When the allowed subset is empty, the fill is flagged as no-allocate and the recency state is left untouched. A status output reports when two groups claim the same way.

The recency state is held per set. The cache's tag and data arrays, and coherency, are outside this block. The block reports its fill decision one clock after the request.

Top module: `wp_alloc`

## Requirements
- R1: After reset every group is empty, so every requester may use all 16 ways; `cfg_overlap` is 0, `res_valid` is 0, and the first fill in any set selects way 0.
- R2: A requester whose bit is set in a group's requester mask receives a victim only from that group's way mask.
- R3: A requester in no group receives a victim only from ways that no group's way mask contains.
- R4: When the allowed subset is empty, the fill returns `res_noalloc`=1 with `res_way`=0, and that set's recency state is left unchanged.
- R5: A requester listed in several groups uses the group with the lowest index.
- R6: A hit on way X (`acc_fill`=0) marks X most recent in its set, whatever the partitioning; the next fill in that set does not choose X if another allowed way exists.
- R7: The victim walk starts at the root of the binary tree. A node bit of 0 points to the lower half of the ways and 1 to the upper half, and all bits are 0 after reset. At each node the walk follows the bit if that side holds an allowed way, and takes the other side otherwise. Every access flips each node on its path to point away from the way used. So in a fresh set the 4-way pool 0..3 is filled in the order 0,2,1,3, the group 4..15 first gets way 4, and a full set gets 0 then 8.
- R8: `cfg_overlap` is 1 exactly while two groups' way masks share a bit.
- R9: A group write (`cfg_we` with `cfg_grp`, `cfg_ways`, `cfg_reqs`) takes effect from the next cycle's fill, and it leaves the recency state of every set intact.
- R10: Recency state is kept separately for each set; accesses to one set do not change the victims of another.
- R11: A fill accepted on a clock edge produces exactly one result, with `res_valid`=1, in the following cycle; a hit produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one partition group |
| cfg_grp | input | 2 | Group index to write |
| cfg_ways | input | 16 | Way mask owned by the group |
| cfg_reqs | input | 16 | Requester-ID membership mask of the group |
| cfg_overlap | output | 1 | Two groups claim a common way |
| acc_valid | input | 1 | Access present this cycle |
| acc_fill | input | 1 | 1 = fill needing a victim, 0 = hit |
| acc_set | input | 4 | Set index of the access |
| acc_req | input | 4 | Requester ID of the access |
| acc_hit_way | input | 4 | Way that hit (used when `acc_fill`=0) |
| res_valid | output | 1 | Fill decision is valid |
| res_way | output | 4 | Chosen victim way |
| res_noalloc | output | 1 | Fill must bypass allocation |

## Verification
Fills are issued with several shapes of allowed subset:
- The full cache, an unbalanced 12-way group and the 4-way shared pool. Exact victim orders in fresh sets separate a correct constrained walk from one that ignores the mask or the pointer sense.
- Requesters listed in two groups. These separate the lowest-index rule from a union or a highest-index rule.
- A fully owned cache. Here unassigned requesters get no-allocate, and a following fill proves the state was not touched.

Hits placed just before fills, one of them in a way owned by another group, show that lookups refresh recency without regard to partitions. Reprogramming a group between two fills to the same set, and interleaving fills to two sets, separate per-set state from shared state.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic {
      ACC_HIT  = 1'b0,
      ACC_FILL = 1'b1
   } acc_kind_e;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wp_group_table.sv
module wp_group_table #(
   parameter int unsigned NUM_WAYS   = 16,
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned NUM_REQ    = 16,
   localparam int unsigned GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int unsigned REQ_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [GRP_W-1:0]    cfg_grp,
   input  logic [NUM_WAYS-1:0] cfg_ways,
   input  logic [NUM_REQ-1:0]  cfg_reqs,
   input  logic [REQ_W-1:0]    req_id,
   output logic [NUM_WAYS-1:0] allowed,
   output logic                overlap
);
   logic [NUM_WAYS-1:0] way_q [NUM_GROUPS];
   logic [NUM_REQ-1:0]  req_q [NUM_GROUPS];
   logic [NUM_WAYS-1:0] owned;
   logic [NUM_GROUPS-1:0] clash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            way_q[g] <= '0;
            req_q[g] <= '0;
         end
      end else if (cfg_we) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (cfg_grp == GRP_W'(g)) begin
               way_q[g] <= cfg_ways;
               req_q[g] <= cfg_reqs;
            end
         end
      end
   end

   function automatic logic clash_of(int g);
      logic c;
      c = 1'b0;
      for (int h = g + 1; h < NUM_GROUPS; h++) c = c | (|(way_q[g] & way_q[h]));
      return c;
   endfunction

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clash
      assign clash[g] = clash_of(g);
   end
   assign overlap = |clash;

   // Resolve membership: lowest group index wins, else the unowned pool.
   always_comb begin
      owned = '0;
      for (int g = 0; g < NUM_GROUPS; g++) owned = owned | way_q[g];
      allowed = ~owned;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (req_q[g][req_id]) allowed = way_q[g];
      end
   end

   // R9: a group write is visible in the table on the next cycle
   p_group_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (way_q[$past(cfg_grp)] == $past(cfg_ways)) &&
                 (req_q[$past(cfg_grp)] == $past(cfg_reqs)));
endmodule

// File: rtl/wp_plru_pick.sv
module wp_plru_pick #(
   parameter int unsigned NUM_WAYS = 16,
   localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
   localparam int unsigned NODES  = NUM_WAYS - 1,
   localparam int unsigned LEVELS = $clog2(NUM_WAYS)
) (
   input  logic [NODES-1:0]    tree,
   input  logic [NUM_WAYS-1:0] allowed,
   output logic [WAY_W-1:0]    way,
   output logic                empty
);
   logic [2*NUM_WAYS-2:0] avail;
   int unsigned           n;
   logic                  go_r;

   always_comb begin
      avail = '0;
      for (int w = 0; w < NUM_WAYS; w++) avail[NODES + w] = allowed[w];
      for (int k = NODES - 1; k >= 0; k--) avail[k] = avail[2*k+1] | avail[2*k+2];
      n = 0;
      go_r = 1'b0;
      for (int l = 0; l < LEVELS; l++) begin
         go_r = tree[n] ? avail[2*n+2] : !avail[2*n+1];
         n = 2*n + 1 + {31'd0, go_r};
      end
      way   = WAY_W'(n - NODES);
      empty = !avail[0];
   end
endmodule

// File: rtl/wp_alloc.sv
module wp_alloc #(
   parameter int unsigned NUM_WAYS   = 16,
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned NUM_REQ    = 16,
   parameter int unsigned NUM_SETS   = 16,
   localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
   localparam int unsigned NODES  = NUM_WAYS - 1,
   localparam int unsigned LEVELS = $clog2(NUM_WAYS),
   localparam int unsigned GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int unsigned REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int unsigned SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [GRP_W-1:0]    cfg_grp,
   input  logic [NUM_WAYS-1:0] cfg_ways,
   input  logic [NUM_REQ-1:0]  cfg_reqs,
   output logic                cfg_overlap,
   input  logic                acc_valid,
   input  logic                acc_fill,
   input  logic [SET_W-1:0]    acc_set,
   input  logic [REQ_W-1:0]    acc_req,
   input  logic [WAY_W-1:0]    acc_hit_way,
   output logic                res_valid,
   output logic [WAY_W-1:0]    res_way,
   output logic                res_noalloc
);
   import wp_pkg::*;

   if (!is_pow2(NUM_WAYS) || NUM_WAYS < 2) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (!is_pow2(NUM_SETS)) begin : g_bad_sets
      $error("NUM_SETS must be a power of two");
   end
   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("NUM_GROUPS must be at least 1");
   end

   logic [NODES-1:0]    tree_q [NUM_SETS];
   logic [NODES-1:0]    cur_tree, nxt_tree;
   logic [NUM_WAYS-1:0] allowed, allowed_q;
   logic [WAY_W-1:0]    pick_way, upd_way;
   logic                pick_empty, do_upd;
   acc_kind_e           kind;
   int unsigned         n;

   wp_group_table #(
      .NUM_WAYS(NUM_WAYS), .NUM_GROUPS(NUM_GROUPS), .NUM_REQ(NUM_REQ)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_grp(cfg_grp),
      .cfg_ways(cfg_ways), .cfg_reqs(cfg_reqs), .req_id(acc_req),
      .allowed(allowed), .overlap(cfg_overlap)
   );

   assign cur_tree = tree_q[acc_set];

   wp_plru_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .tree(cur_tree), .allowed(allowed), .way(pick_way), .empty(pick_empty)
   );

   assign kind    = acc_kind_e'(acc_fill);
   assign upd_way = (kind == ACC_FILL) ? pick_way : acc_hit_way;
   assign do_upd  = acc_valid && ((kind == ACC_HIT) || !pick_empty);

   // Point every node on the accessed way's path away from it.
   always_comb begin
      nxt_tree = cur_tree;
      n = 0;
      for (int l = 0; l < LEVELS; l++) begin
         nxt_tree[n] = !upd_way[LEVELS-1-l];
         n = 2*n + 1 + {31'd0, upd_way[LEVELS-1-l]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
         res_valid   <= 1'b0;
         res_way     <= '0;
         res_noalloc <= 1'b0;
         allowed_q   <= '0;
      end else begin
         if (do_upd) tree_q[acc_set] <= nxt_tree;
         res_valid   <= acc_valid && (kind == ACC_FILL);
         res_way     <= pick_empty ? '0 : pick_way;
         res_noalloc <= pick_empty;
         allowed_q   <= allowed;
      end
   end

   // R2/R3: the victim lies in the subset resolved from the requester
   p_victim_in_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_noalloc) |-> allowed_q[res_way]);

   // R4: no-allocate is reported exactly when the subset was empty
   p_noalloc_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_noalloc == (allowed_q == '0)));

   // R11: every accepted fill yields a result in the next cycle
   p_fill_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_fill) |=> res_valid);

   // R11: hits and idle cycles produce no result
   p_hit_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_fill) |=> !res_valid);
endmodule

// File: tb/wp_alloc_tb.sv
module wp_alloc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_grp = '0;
   logic [15:0] cfg_ways = '0;
   logic [15:0] cfg_reqs = '0;
   logic        cfg_overlap;
   logic        acc_valid = 1'b0;
   logic        acc_fill = 1'b0;
   logic [3:0]  acc_set = '0;
   logic [3:0]  acc_req = '0;
   logic [3:0]  acc_hit_way = '0;
   logic        res_valid;
   logic [3:0]  res_way;
   logic        res_noalloc;

   typedef struct {
      logic [15:0] mask;
      int          exact;
      int          excl;
      bit          noalloc;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   obs_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   wp_alloc u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_grp(cfg_grp),
      .cfg_ways(cfg_ways), .cfg_reqs(cfg_reqs), .cfg_overlap(cfg_overlap),
      .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
      .acc_req(acc_req), .acc_hit_way(acc_hit_way), .res_valid(res_valid),
      .res_way(res_way), .res_noalloc(res_noalloc)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as results appear
   always @(posedge clk) begin
      #2;
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 result without a pending fill", int'(res_way), -1);
         end else begin
            exp_t e;
            bit   ok;
            e = exp_q.pop_front();
            ok = (res_noalloc == e.noalloc) &&
                 (e.noalloc ? (res_way == 4'd0) :
                  (e.mask[res_way] && (e.exact < 0 || int'(res_way) == e.exact) &&
                   (e.excl < 0 || int'(res_way) != e.excl)));
            chk(ok, e.tag, res_noalloc ? -1 : int'(res_way), e.noalloc ? -1 : e.exact);
            obs_q.push_back(int'(res_way));
         end
      end
   end

   task automatic cfg(input int g, input logic [15:0] w, input logic [15:0] r);
      @(negedge clk);
      cfg_we = 1'b1; cfg_grp = g[1:0]; cfg_ways = w; cfg_reqs = r;
      @(posedge clk); #3;
      cfg_we = 1'b0;
   endtask

   task automatic fill(input int s, input int rq, input logic [15:0] m,
                       input int ex, input int xc, input bit na, input string tag);
      exp_t e;
      e.mask = m; e.exact = ex; e.excl = xc; e.noalloc = na; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      acc_valid = 1'b1; acc_fill = 1'b1; acc_set = s[3:0]; acc_req = rq[3:0];
      @(posedge clk); #3;
      acc_valid = 1'b0;
   endtask

   task automatic hit(input int s, input int w);
      @(negedge clk);
      acc_valid = 1'b1; acc_fill = 1'b0; acc_set = s[3:0]; acc_hit_way = w[3:0];
      @(posedge clk); #3;
      acc_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0, "R1 reset res_valid", int'(res_valid), 0);
      chk(cfg_overlap == 1'b0, "R1 reset overlap", int'(cfg_overlap), 0);
      rst_n = 1'b1;

      fill(0, 0, 16'hffff, 0, -1, 0, "R1 first victim after reset");
      fill(0, 3, 16'hffff, 8, -1, 0, "R7 second victim in full set");

      cfg(0, 16'hfff0, 16'h0001);
      fill(1, 0, 16'hfff0, 4, -1, 0, "R7 first victim in 12-way group");
      for (int i = 0; i < 7; i++) fill(1, 0, 16'hfff0, -1, -1, 0, "R2 victim within group");

      // R3/R7: shared pool 0..3 for requester 5 in fresh set 2
      fill(2, 5, 16'h000f, 0, -1, 0, "R3 pool order step 0");
      fill(2, 5, 16'h000f, 2, -1, 0, "R3 pool order step 1");
      fill(2, 5, 16'h000f, 1, -1, 0, "R7 pool order step 2");
      fill(2, 5, 16'h000f, 3, -1, 0, "R7 pool order step 3");

      // R6: hits refresh recency; hit in another group's way is silent (R11)
      hit(3, 0);
      fill(3, 5, 16'h000f, -1, 0, 0, "R6 hit way not chosen next");
      hit(3, 9);
      hit(3, 1);
      fill(3, 5, 16'h000f, -1, 1, 0, "R6 recent hit way not chosen");

      // R4: all ways owned, unassigned requester gets no-allocate
      cfg(1, 16'h000f, 16'h0002);
      fill(4, 5, 16'h0000, -1, -1, 1, "R4 empty subset no-allocate");
      fill(4, 1, 16'h000f, 0, -1, 0, "R4 state untouched by no-allocate");

      // R5: requesters 0 and 1 also listed in group 2
      cfg(0, 16'hff00, 16'h0001);
      cfg(2, 16'h00f0, 16'h0003);
      fill(5, 0, 16'hff00, 8, -1, 0, "R5 lowest group wins for req 0");
      fill(6, 1, 16'h000f, 0, -1, 0, "R5 lowest group wins for req 1");
      fill(6, 2, 16'h0000, -1, -1, 1, "R4 no pool left for req 2");

      // R8: overlap status
      cfg(3, 16'h0100, 16'h0000);
      chk(cfg_overlap == 1'b1, "R8 overlap raised", int'(cfg_overlap), 1);
      cfg(3, 16'h0000, 16'h0000);
      chk(cfg_overlap == 1'b0, "R8 overlap cleared", int'(cfg_overlap), 0);

      // R9: reprogram between fills to the same set
      fill(7, 0, 16'hff00, 8, -1, 0, "R9 fill before reprogram");
      cfg(0, 16'hf000, 16'h0001);
      fill(7, 0, 16'hf000, 12, -1, 0, "R9 new mask with kept state");

      // R10: interleaved sets
      fill(9, 1, 16'h000f, 0, -1, 0, "R10 set 9 first");
      fill(10, 1, 16'h000f, 0, -1, 0, "R10 set 10 unaffected by set 9");
      fill(9, 1, 16'h000f, 2, -1, 0, "R10 set 9 continues");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R11 every fill produced a result", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule